// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address for each beat of a short burst on a pipelined synchronous memory. When a burst is loaded, it captures a full external address and records whether the burst is a read or a write. On each advance cycle after that, it steps only the low address bits. The low field is two bits by default, so a burst has four beats.

The stepping order comes from a mode input. In linear order the low field counts up and wraps to zero. In interleaved order the low field is the starting value XOR-ed with the beat count. Everything above the low field stays as it was loaded.

A single control pin chooses between load (low) and advance (high). A clock-enable input freezes all state while it is low. While a burst advances, the write input is ignored: the access type recorded at load time holds until the next load.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `cur_addr` is all zeros and `cur_wr` is 0 (read).
- R2: A load edge (`clk_en`=1, `adv_nload`=0) makes `cur_addr` equal to `ext_addr` after that edge. It makes `cur_wr` equal to `ext_wr` (1 = write, 0 = read) and clears the beat count.
- R3: With `ilv_mode`=0 (linear), the low field after the k-th advance is (start + k) mod 4. Starting from 00, 01, 10 and 11 this gives 00-01-10-11, 01-10-11-00, 10-11-00-01 and 11-00-01-10.
- R4: With `ilv_mode`=1 (interleaved), the low field after the k-th advance is start XOR (k mod 4). Starting from 00, 01, 10 and 11 this gives 00-01-10-11, 01-00-11-10, 10-11-00-01 and 11-10-01-00.
- R5: An advance never changes `cur_addr` bits above the low field. Wrapping the low field never carries into them.
- R6: During an advance `ext_wr` has no effect: `cur_wr` keeps the value latched at load.
- R7: An edge with `clk_en`=0 leaves `cur_addr` and `cur_wr` unchanged, whatever the other inputs are.
- R8: Advancing past the fourth beat continues the wrap: the fifth address equals the first.
- R9: A change of `ilv_mode` does not alter `cur_addr` until the next advance. That advance computes its value in the new order from the start value and the beat count.
- R10: A load in the middle of a burst restarts the sequence from the new external address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Clock qualifier; 0 freezes all state |
| adv_nload | input | 1 | 1 = advance burst, 0 = load new address |
| ext_addr | input | ADDR_W | External address captured on load |
| ext_wr | input | 1 | Access type captured on load (1 = write) |
| ilv_mode | input | 1 | Order select: 0 linear, 1 interleaved |
| cur_addr | output | ADDR_W | Address of the current beat |
| cur_wr | output | 1 | Access type of the current burst |

## Verification
The linear-step property assumes `ilv_mode` stays steady between a load and the advances that follow it. The checker therefore records the mode seen at each load and switches that property off once the mode differs within the burst. The other properties (load capture, freeze, upper bits and type held during advance) assume nothing about the inputs beyond a known reset. The stimulus keeps the mode constant in its sweep over start values, types and modes. It changes the mode mid-burst only in one dedicated sequence, which the checker's guard covers.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
   typedef enum logic {
      ACC_RD = 1'b0,
      ACC_WR = 1'b1
   } acc_kind_e;
endpackage

// File: rtl/burst_lo_next.sv
module burst_lo_next #(
   parameter int BURST_W = 2
) (
   input  logic [BURST_W-1:0] base_lo,
   input  logic [BURST_W-1:0] beat_nxt,
   input  logic               ilv,
   output logic [BURST_W-1:0] lo_nxt
);
   logic [BURST_W-1:0] lin_lo;
   logic [BURST_W-1:0] ilv_lo;

   // Linear order: modular add, carry beyond the field is dropped.
   assign lin_lo = base_lo + beat_nxt;

   // Interleaved order: per-bit XOR of start value and beat count.
   genvar gi;
   generate
      for (gi = 0; gi < BURST_W; gi++) begin : g_ilv_bit
         assign ilv_lo[gi] = base_lo[gi] ^ beat_nxt[gi];
      end
   endgenerate

   assign lo_nxt = ilv ? ilv_lo : lin_lo;
endmodule

// File: rtl/burst_beat_cnt.sv
module burst_beat_cnt #(
   parameter int BURST_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clk_en,
   input  logic               adv_nload,
   output logic [BURST_W-1:0] beat_nxt
);
   logic [BURST_W-1:0] beat_q;

   assign beat_nxt = beat_q + BURST_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         beat_q <= '0;
      end else if (clk_en) begin
         if (adv_nload) beat_q <= beat_nxt;
         else           beat_q <= '0;
      end
   end
endmodule

// File: rtl/burst_addr_regs.sv
module burst_addr_regs
   import burst_seq_pkg::*;
#(
   parameter int ADDR_W  = 20,
   parameter int BURST_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clk_en,
   input  logic               adv_nload,
   input  logic [ADDR_W-1:0]  ext_addr,
   input  logic               ext_wr,
   input  logic [BURST_W-1:0] lo_nxt,
   output logic [BURST_W-1:0] base_lo,
   output logic [ADDR_W-1:0]  addr_q,
   output acc_kind_e          kind_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         base_lo <= '0;
         kind_q  <= ACC_RD;
      end else if (clk_en) begin
         if (!adv_nload) begin
            addr_q  <= ext_addr;
            base_lo <= ext_addr[BURST_W-1:0];
            kind_q  <= ext_wr ? ACC_WR : ACC_RD;
         end else begin
            addr_q[BURST_W-1:0] <= lo_nxt;
         end
      end
   end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
   import burst_seq_pkg::*;
#(
   parameter int ADDR_W  = 20,
   parameter int BURST_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clk_en,
   input  logic              adv_nload,
   input  logic [ADDR_W-1:0] ext_addr,
   input  logic              ext_wr,
   input  logic              ilv_mode,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              cur_wr
);
   localparam int BEATS = 1 << BURST_W;

   generate
      if (BURST_W < 1 || BURST_W >= ADDR_W) begin : g_bad_width
         $error("burst_addr_seq: BURST_W must be 1..ADDR_W-1");
      end
      if (BEATS > 256) begin : g_bad_beats
         $error("burst_addr_seq: burst length too large");
      end
   endgenerate

   logic [BURST_W-1:0] beat_nxt;
   logic [BURST_W-1:0] base_lo;
   logic [BURST_W-1:0] lo_nxt;
   acc_kind_e          kind_q;

   burst_beat_cnt #(.BURST_W(BURST_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .clk_en    (clk_en),
      .adv_nload (adv_nload),
      .beat_nxt  (beat_nxt)
   );

   burst_lo_next #(.BURST_W(BURST_W)) u_next (
      .base_lo  (base_lo),
      .beat_nxt (beat_nxt),
      .ilv      (ilv_mode),
      .lo_nxt   (lo_nxt)
   );

   burst_addr_regs #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .clk_en    (clk_en),
      .adv_nload (adv_nload),
      .ext_addr  (ext_addr),
      .ext_wr    (ext_wr),
      .lo_nxt    (lo_nxt),
      .base_lo   (base_lo),
      .addr_q    (cur_addr),
      .kind_q    (kind_q)
   );

   assign cur_wr = (kind_q == ACC_WR);
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
   parameter int ADDR_W  = 20,
   parameter int BURST_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clk_en,
   input logic              adv_nload,
   input logic [ADDR_W-1:0] ext_addr,
   input logic              ext_wr,
   input logic              ilv_mode,
   input logic [ADDR_W-1:0] cur_addr,
   input logic              cur_wr
);
   logic ld_mode;
   logic mixed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ld_mode <= 1'b0;
         mixed   <= 1'b0;
      end else if (clk_en && !adv_nload) begin
         ld_mode <= ilv_mode;
         mixed   <= 1'b0;
      end else if (ilv_mode != ld_mode) begin
         mixed   <= 1'b1;
      end
   end

   assert_load_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && !adv_nload) |=> (cur_addr == $past(ext_addr)) && (cur_wr == $past(ext_wr)));

   assert_linear_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && adv_nload && !ilv_mode && !ld_mode && !mixed)
      |=> cur_addr[BURST_W-1:0] == BURST_W'($past(cur_addr[BURST_W-1:0]) + BURST_W'(1)));

   assert_upper_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && adv_nload) |=> $stable(cur_addr[ADDR_W-1:BURST_W]));

   assert_type_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && adv_nload) |=> $stable(cur_wr));

   assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en |=> ($stable(cur_addr) && $stable(cur_wr)));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .clk_en    (clk_en),
   .adv_nload (adv_nload),
   .ext_addr  (ext_addr),
   .ext_wr    (ext_wr),
   .ilv_mode  (ilv_mode),
   .cur_addr  (cur_addr),
   .cur_wr    (cur_wr)
);

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
   localparam int AW = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clk_en = 1'b0;
   logic          adv_nload = 1'b0;
   logic [AW-1:0] ext_addr = '0;
   logic          ext_wr = 1'b0;
   logic          ilv_mode = 1'b0;
   logic [AW-1:0] cur_addr;
   logic          cur_wr;

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;

   always #4 clk = ~clk;

   burst_addr_seq #(.ADDR_W(AW), .BURST_W(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .adv_nload(adv_nload),
      .ext_addr(ext_addr), .ext_wr(ext_wr), .ilv_mode(ilv_mode),
      .cur_addr(cur_addr), .cur_wr(cur_wr)
   );

   task automatic check(string req, logic [AW-1:0] exp_a, logic exp_w);
      n_chk++;
      if (cur_addr !== exp_a || cur_wr !== exp_w) begin
         n_err++;
         $display("FAIL %s: addr=%h wr=%b expected addr=%h wr=%b",
                  req, cur_addr, cur_wr, exp_a, exp_w);
      end
   endtask

   // Called at a negedge: drive, pass one rising edge, return at next negedge.
   task automatic tick(logic en, logic adv, logic [AW-1:0] a, logic w, logic m);
      clk_en = en; adv_nload = adv; ext_addr = a; ext_wr = w; ilv_mode = m;
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic [1:0] exp_lo(logic [1:0] s, int k, logic m);
      return m ? (s ^ 2'(k % 4)) : 2'((s + k) % 4);
   endfunction

   initial begin
      logic [AW-1:0] up;
      logic [AW-1:0] exp;
      @(negedge clk);
      check("R1", '0, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      for (int m = 0; m < 2; m++) begin
         for (int s = 0; s < 4; s++) begin
            for (int w = 0; w < 2; w++) begin
               up = AW'((m * 8 + s * 2 + w) * 36'h3A5 + 20'h5C000) & ~AW'(3);
               tick(1, 0, up | AW'(s), w[0], m[0]);
               check("R2", up | AW'(s), w[0]);
               for (int k = 1; k <= 6; k++) begin
                  tick(1, 1, ~up, ~w[0], m[0]);
                  exp = up | AW'(exp_lo(2'(s), k, m[0]));
                  if (k == 4) check("R8", up | AW'(s), w[0]);
                  else if (m == 0) check("R3 R5 R6", exp, w[0]);
                  else check("R4 R5 R6", exp, w[0]);
                  if (k == 2) begin
                     tick(0, 0, '1, ~w[0], m[0]);
                     check("R7", exp, w[0]);
                  end
               end
            end
         end
      end
      // Mode switch within a burst.
      tick(1, 0, 20'hABCD1, 1'b1, 1'b0);
      tick(1, 1, '0, 1'b0, 1'b0);
      check("R3", 20'hABCD2, 1'b1);
      tick(0, 1, '0, 1'b0, 1'b1);
      check("R9", 20'hABCD2, 1'b1);
      tick(1, 1, '0, 1'b0, 1'b1);
      check("R9", 20'hABCD3, 1'b1);
      tick(1, 1, '0, 1'b0, 1'b0);
      check("R9", 20'hABCD0, 1'b1);
      // Reload mid-burst.
      tick(1, 0, 20'h12342, 1'b0, 1'b1);
      check("R10", 20'h12342, 1'b0);
      tick(1, 1, '0, 1'b1, 1'b1);
      check("R10", 20'h12343, 1'b0);
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule